// File: doc/BRIEF.md
# RS-485 Nine-Bit Serial Transmitter with Automatic Driver Enable

This block serializes characters for a multidrop RS-485 bus. Software places characters into a small transmit queue through a write port. Each entry carries eight payload bits and a flag that marks it as a station address or as ordinary payload. The block sends each character as one asynchronous frame whose ninth bit carries that flag, so that receivers on the bus can tell addresses from data. Bit timing comes from an external baud tick, and each bit lasts from one tick to the next.

When automatic direction control is switched on, the block drives the transceiver's driver-enable pin. The pin turns active in the cycle after a character is accepted into the queue. It stays active across characters queued back to back, and it turns inactive only once the stop bit of the last queued character has ended. A polarity input chooses whether the active level is low or high. When direction control is off, the pin rests at its inactive level. A write to a full queue is dropped, and this raises an overflow flag that stays set until reset.

Top module: `rs485_tx9`

## Requirements
- R1: A frame is a start bit at 0, then the eight payload bits least significant first, then the ninth bit, then a stop bit at 1, for eleven bits. A frame starts at a baud tick, and each bit holds from that tick to the next. While nothing is being sent, the line rests at 1.
- R2: The ninth bit equals the address flag written with the character: 1 for an address, 0 for data.
- R3: With auto direction on, the direction pin reaches its active level in the cycle after a write is accepted. This happens before any start bit. From that same cycle busy reads 1.
- R4: With auto direction on, the pin stays active through the whole stop bit of the last queued character. It returns to its inactive level, and busy falls to 0, on the tick that ends that stop bit.
- R5: When a character is already queued as a stop bit ends, its start bit begins on that same tick, and the direction pin does not leave its active level between the two frames.
- R6: With dir_pol at 0 the pin is active low. With dir_pol at 1 it is active high.
- R7: With auto direction off, the pin holds its inactive level (the inverse of dir_pol) for the whole transmission.
- R8: With a queue depth of four, a fifth write made before any character has been sent is dropped and sets ovf. ovf then stays at 1 until reset. Only the first four characters are sent.
- R9: After reset, txd is 1, busy is 0, ovf is 0 and the pin is at its inactive level.
- R10: A write that arrives on the very tick that ends the last stop bit keeps the direction pin active. That character is then sent as the next frame, starting at the following tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Queue write strobe, one character per cycle |
| wr_data | input | 8 | Payload byte of the character |
| wr_addr | input | 1 | 1 marks the character as an address |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| auto_dir_en | input | 1 | Enables automatic direction control |
| dir_pol | input | 1 | Active level of the direction pin (0 is low, 1 is high) |
| txd | output | 1 | Serial line |
| dir | output | 1 | Transceiver direction pin |
| busy | output | 1 | A character is queued or being sent |
| ovf | output | 1 | Sticky flag for a dropped write |

## Verification
Two events can land in the same cycle: the serializer finishing its last stop bit with an empty queue, and a new write from software. The bench provokes this by raising wr_en in the very cycle of the closing baud tick. It then judges the result on three counts. The direction pin must never show its inactive level. The line must rest high until the next tick. The late character must then come out as a complete frame. A second overlap, a write hitting a full queue, is judged by counting the frames that come out and by watching the sticky flag.

// File: rtl/rs485_tx9_pkg.sv
package rs485_tx9_pkg;
  parameter int unsigned CHAR_BITS = 8;

  typedef struct packed {
    logic                 is_addr;
    logic [CHAR_BITS-1:0] payload;
  } char_t;

  typedef enum logic {
    SER_IDLE = 1'b0,
    SER_SEND = 1'b1
  } ser_state_t;
endpackage

// File: rtl/rs485_tx9_fifo.sv
module rs485_tx9_fifo
  import rs485_tx9_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  char_t push_char,
  input  logic  pop,
  output char_t head_char,
  output logic  empty,
  output logic  ovf
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  char_t         mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ovf_q, ovf_n;
  logic          full, push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    ovf_n  = ovf_q | (push & full);
    if (push_ok) wptr_n = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop_ok)  rptr_n = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
      ovf_q  <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_char;
  end

  assign head_char = mem[rptr_q];
  assign ovf       = ovf_q;
endmodule

// File: rtl/rs485_tx9_ser.sv
module rs485_tx9_ser
  import rs485_tx9_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  baud_tick,
  input  logic  have_char,
  input  char_t head_char,
  output logic  pop,
  output logic  active,
  output logic  txd
);
  localparam int unsigned FRAME = CHAR_BITS + 3;
  localparam int unsigned BW    = $clog2(FRAME);

  ser_state_t       state_q, state_n;
  logic [FRAME-1:0] shreg_q, shreg_n;
  logic [BW-1:0]    bit_q, bit_n;
  logic             last_bit, load;

  assign last_bit = (bit_q == BW'(FRAME - 1));
  assign load     = baud_tick & have_char & ((state_q == SER_IDLE) | last_bit);

  always_comb begin
    state_n = state_q;
    shreg_n = shreg_q;
    bit_n   = bit_q;
    if (load) begin
      shreg_n = {1'b1, head_char.is_addr, head_char.payload, 1'b0};
      bit_n   = '0;
      state_n = SER_SEND;
    end else if (baud_tick && state_q == SER_SEND) begin
      if (last_bit) begin
        state_n = SER_IDLE;
      end else begin
        shreg_n = {1'b1, shreg_q[FRAME-1:1]};
        bit_n   = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      shreg_q <= '1;
      bit_q   <= '0;
    end else begin
      state_q <= state_n;
      shreg_q <= shreg_n;
      bit_q   <= bit_n;
    end
  end

  assign pop    = load;
  assign active = (state_q == SER_SEND);
  assign txd    = active ? shreg_q[0] : 1'b1;
endmodule

// File: rtl/rs485_tx9_dir.sv
module rs485_tx9_dir (
  input  logic sending,
  input  logic pending,
  input  logic auto_en,
  input  logic pol_high,
  output logic dir
);
  logic drive_on;

  assign drive_on = auto_en & (sending | pending);
  assign dir      = pol_high ? drive_on : ~drive_on;
endmodule

// File: rtl/rs485_tx9.sv
module rs485_tx9
  import rs485_tx9_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CHAR_BITS-1:0] wr_data,
  input  logic                 wr_addr,
  input  logic                 baud_tick,
  input  logic                 auto_dir_en,
  input  logic                 dir_pol,
  output logic                 txd,
  output logic                 dir,
  output logic                 busy,
  output logic                 ovf
);
  char_t in_char, head_char;
  logic  fifo_empty, pop, ser_active;

  assign in_char.is_addr = wr_addr;
  assign in_char.payload = wr_data;

  rs485_tx9_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_en),
    .push_char (in_char),
    .pop       (pop),
    .head_char (head_char),
    .empty     (fifo_empty),
    .ovf       (ovf)
  );

  rs485_tx9_ser u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .have_char (~fifo_empty),
    .head_char (head_char),
    .pop       (pop),
    .active    (ser_active),
    .txd       (txd)
  );

  rs485_tx9_dir u_dir (
    .sending  (ser_active),
    .pending  (~fifo_empty),
    .auto_en  (auto_dir_en),
    .pol_high (dir_pol),
    .dir      (dir)
  );

  assign busy = ser_active | ~fifo_empty;
endmodule

// File: rtl/rs485_tx9_chk.sv
module rs485_tx9_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic auto_dir_en,
  input logic dir_pol,
  input logic txd,
  input logic dir,
  input logic busy,
  input logic ovf
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  a_r1_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> txd);

  a_r3_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy);

  a_r4_dir_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    auto_dir_en |-> ((dir == dir_pol) == busy));

  a_r7_dir_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_dir_en |-> (dir != dir_pol));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

bind rs485_tx9 rs485_tx9_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .auto_dir_en (auto_dir_en),
  .dir_pol     (dir_pol),
  .txd         (txd),
  .dir         (dir),
  .busy        (busy),
  .ovf         (ovf)
);

// File: tb/rs485_tx9_tb.sv
module rs485_tx9_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_addr, baud_tick, auto_dir_en, dir_pol;
  logic [7:0] wr_data;
  logic       txd, dir, busy, ovf;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  rs485_tx9 u_dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .wr_addr (wr_addr), .baud_tick (baud_tick), .auto_dir_en (auto_dir_en),
    .dir_pol (dir_pol), .txd (txd), .dir (dir), .busy (busy), .ovf (ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
    baud_tick = 1'b0; auto_dir_en = 1'b1; dir_pol = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick(input logic with_wr, input logic a, input logic [7:0] d);
    @(negedge clk);
    baud_tick = 1'b1;
    wr_en = with_wr; wr_addr = a; wr_data = d;
    @(negedge clk);
    baud_tick = 1'b0;
    wr_en = 1'b0;
  endtask

  task automatic write_char(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Eleven ticks; after each one the line must show the expected bit.
  task automatic frame(input logic a, input logic [7:0] d, input logic exp_dir, input string dir_req);
    for (int k = 0; k < 11; k++) begin
      logic eb;
      tick(1'b0, 1'b0, 8'h00);
      if (k == 0) eb = 1'b0;
      else if (k <= 8) eb = d[k-1];
      else if (k == 9) eb = a;
      else eb = 1'b1;
      chk((k == 9) ? "R2 ninth bit" : "R1 frame bit", {31'd0, txd}, {31'd0, eb});
      chk(dir_req, {31'd0, dir}, {31'd0, exp_dir});
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 txd", {31'd0, txd}, 32'd1);
    chk("R9 busy", {31'd0, busy}, 32'd0);
    chk("R9 ovf", {31'd0, ovf}, 32'd0);
    chk("R9 dir", {31'd0, dir}, 32'd1);
  endtask

  task automatic t_single();
    write_char(1'b0, 8'hA5);
    chk("R3 dir after write", {31'd0, dir}, 32'd0);
    chk("R3 busy after write", {31'd0, busy}, 32'd1);
    chk("R3 line idle before tick", {31'd0, txd}, 32'd1);
    frame(1'b0, 8'hA5, 1'b0, "R4 dir held in frame");
    tick(1'b0, 1'b0, 8'h00);
    chk("R4 dir released", {31'd0, dir}, 32'd1);
    chk("R4 busy released", {31'd0, busy}, 32'd0);
    chk("R1 idle line", {31'd0, txd}, 32'd1);
  endtask

  task automatic t_addr();
    write_char(1'b1, 8'h3C);
    frame(1'b1, 8'h3C, 1'b0, "R4 dir held in addr frame");
    tick(1'b0, 1'b0, 8'h00);
    chk("R4 dir released addr", {31'd0, dir}, 32'd1);
  endtask

  task automatic t_b2b();
    write_char(1'b0, 8'h81);
    write_char(1'b1, 8'h7E);
    frame(1'b0, 8'h81, 1'b0, "R5 dir held first");
    frame(1'b1, 8'h7E, 1'b0, "R5 dir held second");
    tick(1'b0, 1'b0, 8'h00);
    chk("R5 dir released", {31'd0, dir}, 32'd1);
    chk("R5 busy released", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_pol();
    dir_pol = 1'b1;
    @(negedge clk);
    chk("R6 idle high pol", {31'd0, dir}, 32'd0);
    write_char(1'b0, 8'h5A);
    chk("R6 active high", {31'd0, dir}, 32'd1);
    frame(1'b0, 8'h5A, 1'b1, "R6 dir held high");
    tick(1'b0, 1'b0, 8'h00);
    chk("R6 released low", {31'd0, dir}, 32'd0);
    dir_pol = 1'b0;
  endtask

  task automatic t_noauto();
    auto_dir_en = 1'b0;
    write_char(1'b1, 8'hF0);
    chk("R7 dir inactive queued", {31'd0, dir}, 32'd1);
    frame(1'b1, 8'hF0, 1'b1, "R7 dir inactive");
    tick(1'b0, 1'b0, 8'h00);
    chk("R7 busy done", {31'd0, busy}, 32'd0);
    auto_dir_en = 1'b1;
  endtask

  task automatic t_edge();
    write_char(1'b0, 8'h55);
    frame(1'b0, 8'h55, 1'b0, "R4 dir held edge frame");
    tick(1'b1, 1'b1, 8'hC3);
    chk("R10 dir kept", {31'd0, dir}, 32'd0);
    chk("R10 busy kept", {31'd0, busy}, 32'd1);
    chk("R10 line idle", {31'd0, txd}, 32'd1);
    frame(1'b1, 8'hC3, 1'b0, "R10 dir held late frame");
    tick(1'b0, 1'b0, 8'h00);
    chk("R10 released", {31'd0, dir}, 32'd1);
  endtask

  task automatic t_ovf();
    do_reset();
    for (int i = 0; i < 5; i++) write_char(1'b0, 8'(8'h10 + i));
    chk("R8 ovf set", {31'd0, ovf}, 32'd1);
    for (int i = 0; i < 4; i++) frame(1'b0, 8'(8'h10 + i), 1'b0, "R8 dir held");
    tick(1'b0, 1'b0, 8'h00);
    chk("R8 fifth dropped busy", {31'd0, busy}, 32'd0);
    repeat (20) @(negedge clk);
    chk("R8 fifth dropped line", {31'd0, txd}, 32'd1);
    chk("R8 ovf sticky", {31'd0, ovf}, 32'd1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_addr();
    t_b2b();
    t_pol();
    t_noauto();
    t_edge();
    t_ovf();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule